// File: doc/BRIEF.md
# Shared External Memory Bus Interface

This block puts three internal request sources onto one external memory bus: a program-memory port, a data-memory port and a read-only boot source. Only one source owns the bus at a time. The owner's address goes onto the shared address lines, and write data goes onto the shared data lines. An active-low select strobe shows which of the three spaces is being accessed, and separate read and write strobes show the direction. Each space has its own programmable wait-state count, which stretches every access so that slow memories and memory-mapped peripherals can be used.

An external master can take the bus. It drives a bus-request input low, and the interface answers on an active-low grant output. The grant is given only once the current access has finished. While the bus is granted, the interface stops driving the address, data and strobe lines. A mode input chooses what the core does during a grant. In one mode it carries on from internal memory, and only its external requests wait. In the other mode a halt output holds the whole core for as long as the grant lasts.

Top module: `ext_mem_bus_if`

## Requirements
- R1: While reset is held, and in the first cycle after it, the outputs are idle. The three select strobes, `ext_rd_n`, `ext_wr_n` and `ext_busgnt_n` are all high. `ext_drive_oe` is high, `ext_dout_oe` is low, `core_halt` is low, and every ready output is high while its port is not requesting.
- R2: The bus samples a request while it is idle. In the next cycle the access begins, and the space's select strobe stays low for exactly W+1 cycles, where W is that space's wait-state count. The port's ready output goes high in the last of those cycles.
- R3: After reset the boot space uses 3 wait states, and the program and data spaces use 7.
- R4: A configuration write with `cfg_space` 0 (boot), 1 (program) or 2 (data) sets that space's count from `cfg_ws`. The new count applies only to accesses that start after the write. An access already under way keeps its count, and `cfg_space` 3 changes nothing.
- R5: During an access `ext_addr` carries the owning port's address, held for the whole access. A read drives `ext_rd_n` low and `rd_data` follows `ext_din`. A write drives `ext_wr_n` low and `ext_dout_oe` high, and puts the write data on `ext_dout`.
- R6: When the bus is idle and several sources are requesting, data beats program and program beats boot. The loser gets the bus in the second cycle after the winner's ready output goes high.
- R7: A port that is requesting sees its ready output low in every cycle except the one in which its access completes.
- R8: A bus request that arrives during an access is not answered until that access has finished. When the bus is idle, a bus request beats an internal request, and `ext_busgnt_n` goes low in the next cycle. While the grant lasts, `ext_drive_oe` and `ext_dout_oe` are low and every strobe is high.
- R9: When the bus request goes away, `ext_busgnt_n` goes high in the next cycle. A request that waited through the grant then gets the bus one cycle later.
- R10: `core_halt` is high exactly while the bus is granted and `grant_run_mode` is 0. With `grant_run_mode` 1 it stays low during a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_req | input | 1 | Boot source read request |
| boot_addr | input | ADDR_W | Boot read address |
| boot_rdy | output | 1 | Boot access ready |
| prog_req | input | 1 | Program port request |
| prog_we | input | 1 | Program port write (1) or read (0) |
| prog_addr | input | ADDR_W | Program port address |
| prog_wdata | input | DATA_W | Program port write data |
| prog_rdy | output | 1 | Program port ready |
| data_req | input | 1 | Data port request |
| data_we | input | 1 | Data port write (1) or read (0) |
| data_addr | input | ADDR_W | Data port address |
| data_wdata | input | DATA_W | Data port write data |
| data_rdy | output | 1 | Data port ready |
| rd_data | output | DATA_W | Read data returned to the completing port |
| cfg_we | input | 1 | Wait-state register write enable |
| cfg_space | input | 2 | Space whose count is written (0 boot, 1 program, 2 data) |
| cfg_ws | input | WS_W | New wait-state count |
| grant_run_mode | input | 1 | 1: core keeps running during a grant; 0: core halts |
| ext_addr | output | ADDR_W | Shared external address |
| ext_dout | output | DATA_W | External write data |
| ext_dout_oe | output | 1 | Drive enable for the external data lines |
| ext_din | input | DATA_W | External read data |
| ext_drive_oe | output | 1 | Drive enable for the address and strobe lines |
| ext_boot_sel_n | output | 1 | Boot space select, active low |
| ext_prog_sel_n | output | 1 | Program space select, active low |
| ext_data_sel_n | output | 1 | Data space select, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_busreq_n | input | 1 | External bus request, active low |
| ext_busgnt_n | output | 1 | Bus grant, active low |
| core_halt | output | 1 | Halts the core during a grant in halt mode |

## Verification
Each result has a fixed cycle count from its stimulus. The inputs are driven on the falling edge. A select strobe appears at the next falling edge and then stays low for W+1 falling edges, with ready high on the last of them. A grant appears two falling edges after the access that was holding it off completes. A release shows at the next falling edge, and the waiting access strobes one edge after that. The bench therefore counts falling edges from each stimulus and compares the count with these numbers. It does not wait for a signal to change. A strobe that arrives late, early or stretched changes the count, and the check fails.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
   localparam int NUM_SPACES = 3;
   localparam int SP_BOOT    = 0;
   localparam int SP_PROG    = 1;
   localparam int SP_DATA    = 2;
   localparam int SPACE_W    = 2;

   typedef enum logic [1:0] {
      BUS_IDLE   = 2'd0,
      BUS_ACCESS = 2'd1,
      BUS_GRANT  = 2'd2
   } bus_state_e;
endpackage

// File: rtl/ebi_prio_arb.sv
// Fixed-priority selector: the highest-numbered requester wins.
module ebi_prio_arb #(
   parameter int N     = 3,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any_req,
   output logic [IDX_W-1:0] win_idx
);
   if (N < 2) begin : g_bad_n
      $error("ebi_prio_arb: N must be at least 2");
   end

   always_comb begin
      win_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) win_idx = IDX_W'(i);
      end
   end

   assign any_req = |req;
endmodule

// File: rtl/ebi_ws_regs.sv
// One wait-state register per space, written through a narrow port.
module ebi_ws_regs #(
   parameter int                   NUM      = 3,
   parameter int                   WS_W     = 3,
   parameter int                   SEL_W    = 2,
   parameter logic [NUM*WS_W-1:0]  RST_VALS = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [SEL_W-1:0]      wr_sel,
   input  logic [WS_W-1:0]       wr_val,
   output logic [NUM*WS_W-1:0]   ws_flat
);
   if (NUM > (1 << SEL_W)) begin : g_bad_sel
      $error("ebi_ws_regs: SEL_W too narrow for NUM");
   end

   for (genvar s = 0; s < NUM; s++) begin : g_space
      logic [WS_W-1:0] ws_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            ws_q <= RST_VALS[s*WS_W +: WS_W];
         else if (wr_en && (wr_sel == SEL_W'(s)))
            ws_q <= wr_val;
      end
      assign ws_flat[s*WS_W +: WS_W] = ws_q;
   end
endmodule

// File: rtl/ebi_wait_ctr.sv
// Down-counter for the wait states of one access.
module ebi_wait_ctr #(
   parameter int WS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [WS_W-1:0] load_val,
   output logic            at_zero
);
   logic [WS_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/ext_mem_bus_if.sv
module ext_mem_bus_if #(
   parameter int ADDR_W      = 14,
   parameter int DATA_W      = 24,
   parameter int WS_W        = 3,
   parameter int BOOT_WS_RST = 3,
   parameter int PROG_WS_RST = 7,
   parameter int DATA_WS_RST = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_req,
   input  logic [ADDR_W-1:0] boot_addr,
   output logic              boot_rdy,
   input  logic              prog_req,
   input  logic              prog_we,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [DATA_W-1:0] prog_wdata,
   output logic              prog_rdy,
   input  logic              data_req,
   input  logic              data_we,
   input  logic [ADDR_W-1:0] data_addr,
   input  logic [DATA_W-1:0] data_wdata,
   output logic              data_rdy,
   output logic [DATA_W-1:0] rd_data,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_space,
   input  logic [WS_W-1:0]   cfg_ws,
   input  logic              grant_run_mode,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_dout,
   output logic              ext_dout_oe,
   input  logic [DATA_W-1:0] ext_din,
   output logic              ext_drive_oe,
   output logic              ext_boot_sel_n,
   output logic              ext_prog_sel_n,
   output logic              ext_data_sel_n,
   output logic              ext_rd_n,
   output logic              ext_wr_n,
   input  logic              ext_busreq_n,
   output logic              ext_busgnt_n,
   output logic              core_halt
);
   import ebi_pkg::*;

   localparam int NSP = NUM_SPACES;
   localparam logic [NSP*WS_W-1:0] WS_RESET =
      {WS_W'(DATA_WS_RST), WS_W'(PROG_WS_RST), WS_W'(BOOT_WS_RST)};

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ext_mem_bus_if: widths must be positive");
   end
   if (WS_W < 1 || WS_W > 8) begin : g_bad_ws_w
      $error("ext_mem_bus_if: WS_W must be 1..8");
   end
   if (BOOT_WS_RST >= (1 << WS_W) || PROG_WS_RST >= (1 << WS_W) ||
       DATA_WS_RST >= (1 << WS_W)) begin : g_bad_ws_rst
      $error("ext_mem_bus_if: reset wait count does not fit WS_W");
   end

   // Per-space request vectors, indexed by space number.
   logic [NSP-1:0]             req_vec;
   logic [NSP-1:0]             we_vec;
   logic [NSP-1:0][ADDR_W-1:0] addr_vec;
   logic [NSP-1:0][DATA_W-1:0] wdata_vec;
   logic [NSP-1:0]             rdy_vec;
   logic [NSP-1:0]             sel_act;

   assign req_vec   = {data_req, prog_req, boot_req};
   assign we_vec    = {data_we, prog_we, 1'b0};
   assign addr_vec  = {data_addr, prog_addr, boot_addr};
   assign wdata_vec = {data_wdata, prog_wdata, {DATA_W{1'b0}}};

   logic               any_req;
   logic [SPACE_W-1:0] win_sp;

   ebi_prio_arb #(.N(NSP), .IDX_W(SPACE_W)) u_arb (
      .req     (req_vec),
      .any_req (any_req),
      .win_idx (win_sp)
   );

   logic [NSP*WS_W-1:0] ws_flat;

   ebi_ws_regs #(
      .NUM      (NSP),
      .WS_W     (WS_W),
      .SEL_W    (2),
      .RST_VALS (WS_RESET)
   ) u_ws (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_sel  (cfg_space),
      .wr_val  (cfg_ws),
      .ws_flat (ws_flat)
   );

   bus_state_e         st_q;
   logic [SPACE_W-1:0] cur_sp_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  wdata_q;
   logic               we_q;
   logic               start_acc;
   logic               ctr_zero;
   logic               acc_done;
   logic [WS_W-1:0]    start_ws;

   assign start_acc = (st_q == BUS_IDLE) && ext_busreq_n && any_req;
   assign start_ws  = ws_flat[win_sp*WS_W +: WS_W];

   ebi_wait_ctr #(.WS_W(WS_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_acc),
      .load_val (start_ws),
      .at_zero  (ctr_zero)
   );

   assign acc_done = (st_q == BUS_ACCESS) && ctr_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= BUS_IDLE;
         cur_sp_q <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
         we_q     <= 1'b0;
      end else begin
         unique case (st_q)
            BUS_IDLE: begin
               if (!ext_busreq_n) begin
                  st_q <= BUS_GRANT;
               end else if (any_req) begin
                  st_q     <= BUS_ACCESS;
                  cur_sp_q <= win_sp;
                  addr_q   <= addr_vec[win_sp];
                  wdata_q  <= wdata_vec[win_sp];
                  we_q     <= we_vec[win_sp];
               end
            end
            BUS_ACCESS: begin
               if (ctr_zero) st_q <= BUS_IDLE;
            end
            BUS_GRANT: begin
               if (ext_busreq_n) st_q <= BUS_IDLE;
            end
            default: st_q <= BUS_IDLE;
         endcase
      end
   end

   for (genvar s = 0; s < NSP; s++) begin : g_port
      assign sel_act[s] = (st_q == BUS_ACCESS) && (cur_sp_q == SPACE_W'(s));
      assign rdy_vec[s] = !req_vec[s] || (sel_act[s] && acc_done);
   end

   assign boot_rdy = rdy_vec[SP_BOOT];
   assign prog_rdy = rdy_vec[SP_PROG];
   assign data_rdy = rdy_vec[SP_DATA];
   assign rd_data  = ext_din;

   assign ext_addr       = addr_q;
   assign ext_dout       = wdata_q;
   assign ext_dout_oe    = (st_q == BUS_ACCESS) && we_q;
   assign ext_drive_oe   = (st_q != BUS_GRANT);
   assign ext_boot_sel_n = !sel_act[SP_BOOT];
   assign ext_prog_sel_n = !sel_act[SP_PROG];
   assign ext_data_sel_n = !sel_act[SP_DATA];
   assign ext_rd_n       = !((st_q == BUS_ACCESS) && !we_q);
   assign ext_wr_n       = !((st_q == BUS_ACCESS) && we_q);
   assign ext_busgnt_n   = (st_q != BUS_GRANT);
   assign core_halt      = (st_q == BUS_GRANT) && !grant_run_mode;
endmodule

// File: rtl/ext_mem_bus_if_chk.sv
module ext_mem_bus_if_chk #(
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              boot_req,
   input logic              boot_rdy,
   input logic              prog_req,
   input logic              prog_rdy,
   input logic              data_req,
   input logic              data_rdy,
   input logic              grant_run_mode,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              ext_dout_oe,
   input logic              ext_drive_oe,
   input logic              ext_boot_sel_n,
   input logic              ext_prog_sel_n,
   input logic              ext_data_sel_n,
   input logic              ext_rd_n,
   input logic              ext_wr_n,
   input logic              ext_busreq_n,
   input logic              ext_busgnt_n,
   input logic              core_halt
);
   logic busy;
   assign busy = !ext_rd_n || !ext_wr_n;

   // R5: one space and one direction at a time
   a_r5_one_space: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ext_boot_sel_n, ext_prog_sel_n, ext_data_sel_n}) >= 2);
   a_r5_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rd_n || ext_wr_n);
   // R2: address held for the whole access
   a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ext_addr));
   // R8: no grant while an access strobes
   a_r8_no_gnt_in_access: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ext_busgnt_n);
   // R8: bus released while granted
   a_r8_float: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_busgnt_n |-> (!ext_drive_oe && !ext_dout_oe && ext_boot_sel_n &&
                         ext_prog_sel_n && ext_data_sel_n));
   // R9: grant withdrawn one cycle after request drops
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_busgnt_n && ext_busreq_n) |=> ext_busgnt_n);
   // R7: at most one port completes per cycle
   a_r7_one_done: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({boot_req && boot_rdy && !ext_boot_sel_n,
                prog_req && prog_rdy && !ext_prog_sel_n,
                data_req && data_rdy && !ext_data_sel_n}));
   // R10: halt only in halt mode during a grant
   a_r10_halt_only_granted: assert property (@(posedge clk) disable iff (!rst_n)
      core_halt |-> (!ext_busgnt_n && !grant_run_mode));
   a_r10_halt_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_busgnt_n && !grant_run_mode) |-> core_halt);
endmodule

bind ext_mem_bus_if ext_mem_bus_if_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .boot_req       (boot_req),
   .boot_rdy       (boot_rdy),
   .prog_req       (prog_req),
   .prog_rdy       (prog_rdy),
   .data_req       (data_req),
   .data_rdy       (data_rdy),
   .grant_run_mode (grant_run_mode),
   .ext_addr       (ext_addr),
   .ext_dout_oe    (ext_dout_oe),
   .ext_drive_oe   (ext_drive_oe),
   .ext_boot_sel_n (ext_boot_sel_n),
   .ext_prog_sel_n (ext_prog_sel_n),
   .ext_data_sel_n (ext_data_sel_n),
   .ext_rd_n       (ext_rd_n),
   .ext_wr_n       (ext_wr_n),
   .ext_busreq_n   (ext_busreq_n),
   .ext_busgnt_n   (ext_busgnt_n),
   .core_halt      (core_halt)
);

// File: tb/ext_mem_bus_if_bench.sv
module ext_mem_bus_if_bench;
   localparam int AW = 14;
   localparam int DW = 24;
   localparam int WW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          boot_req = 0, prog_req = 0, data_req = 0;
   logic          prog_we = 0, data_we = 0;
   logic [AW-1:0] boot_addr = '0, prog_addr = '0, data_addr = '0;
   logic [DW-1:0] prog_wdata = '0, data_wdata = '0;
   logic          boot_rdy, prog_rdy, data_rdy;
   logic [DW-1:0] rd_data;
   logic          cfg_we = 0;
   logic [1:0]    cfg_space = '0;
   logic [WW-1:0] cfg_ws = '0;
   logic          grant_run_mode = 1'b0;
   logic [AW-1:0] ext_addr;
   logic [DW-1:0] ext_dout;
   logic          ext_dout_oe, ext_drive_oe;
   logic [DW-1:0] ext_din = 24'h5A3C81;
   logic          ext_boot_sel_n, ext_prog_sel_n, ext_data_sel_n;
   logic          ext_rd_n, ext_wr_n;
   logic          ext_busreq_n = 1'b1;
   logic          ext_busgnt_n, core_halt;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   ext_mem_bus_if u_ext_mem_bus_if (
      .clk(clk), .rst_n(rst_n),
      .boot_req(boot_req), .boot_addr(boot_addr), .boot_rdy(boot_rdy),
      .prog_req(prog_req), .prog_we(prog_we), .prog_addr(prog_addr),
      .prog_wdata(prog_wdata), .prog_rdy(prog_rdy),
      .data_req(data_req), .data_we(data_we), .data_addr(data_addr),
      .data_wdata(data_wdata), .data_rdy(data_rdy),
      .rd_data(rd_data),
      .cfg_we(cfg_we), .cfg_space(cfg_space), .cfg_ws(cfg_ws),
      .grant_run_mode(grant_run_mode),
      .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_dout_oe(ext_dout_oe),
      .ext_din(ext_din), .ext_drive_oe(ext_drive_oe),
      .ext_boot_sel_n(ext_boot_sel_n), .ext_prog_sel_n(ext_prog_sel_n),
      .ext_data_sel_n(ext_data_sel_n),
      .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
      .ext_busreq_n(ext_busreq_n), .ext_busgnt_n(ext_busgnt_n),
      .core_halt(core_halt)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic sel_low(input int sp);
      case (sp)
         0: return !ext_boot_sel_n;
         1: return !ext_prog_sel_n;
         default: return !ext_data_sel_n;
      endcase
   endfunction

   function automatic logic rdy_of(input int sp);
      case (sp)
         0: return boot_rdy;
         1: return prog_rdy;
         default: return data_rdy;
      endcase
   endfunction

   task automatic set_req(input int sp, input logic v, input logic we,
                          input logic [AW-1:0] a, input logic [DW-1:0] wd);
      case (sp)
         0: begin boot_req = v; boot_addr = a; end
         1: begin prog_req = v; prog_we = we; prog_addr = a; prog_wdata = wd; end
         default: begin data_req = v; data_we = we; data_addr = a; data_wdata = wd; end
      endcase
   endtask

   task automatic cfg_write(input int sp, input int ws);
      @(negedge clk);
      cfg_we = 1; cfg_space = 2'(sp); cfg_ws = WW'(ws);
      @(negedge clk);
      cfg_we = 0;
   endtask

   // R2 R5 R7: one access, measured in falling edges
   task automatic run_access(input int sp, input logic we, input logic [AW-1:0] a,
                             input logic [DW-1:0] wd, input int exp_ws, input string tag);
      int n = 0;
      int bad = 0;
      @(negedge clk);
      set_req(sp, 1'b1, we, a, wd);
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         n++;
         if (!sel_low(sp) || ext_addr != a) bad++;
         if (we && (ext_dout != wd || !ext_dout_oe || ext_wr_n)) bad++;
         if (!we && (ext_rd_n || ext_dout_oe)) bad++;
         if (n == 1 && exp_ws > 0)
            chk(!rdy_of(sp), {tag, " R7 ready low while waiting"}, rdy_of(sp), 0);
         if (rdy_of(sp)) begin
            if (!we) chk(rd_data == ext_din, {tag, " R5 read data"}, rd_data, ext_din);
            break;
         end
      end
      set_req(sp, 1'b0, 1'b0, a, wd);
      chk(bad == 0, {tag, " R5 strobe/address/data during access"}, bad, 0);
      chk(n == exp_ws + 1, {tag, " R2 access length"}, n, exp_ws + 1);
      @(negedge clk);
      chk(!sel_low(sp), {tag, " R2 strobe released"}, sel_low(sp), 0);
   endtask

   task automatic test_reset();
      chk(ext_boot_sel_n && ext_prog_sel_n && ext_data_sel_n, "R1 strobes in reset", 0, 1);
      @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(ext_boot_sel_n && ext_prog_sel_n && ext_data_sel_n && ext_rd_n && ext_wr_n,
          "R1 strobes idle", 0, 1);
      chk(ext_busgnt_n && ext_drive_oe && !ext_dout_oe && !core_halt,
          "R1 grant/drive idle", 0, 1);
      chk(boot_rdy && prog_rdy && data_rdy, "R1 ready idle", 0, 1);
   endtask

   task automatic test_defaults();
      run_access(0, 1'b0, 14'h0123, '0, 3, "R3 boot default");
      run_access(1, 1'b0, 14'h2ABC, '0, 7, "R3 prog default");
      run_access(2, 1'b1, 14'h1F0F, 24'hC0FFEE, 7, "R3 data default");
   endtask

   task automatic test_cfg();
      cfg_write(2, 0);
      cfg_write(1, 2);
      cfg_write(0, 5);
      run_access(2, 1'b0, 14'h0042, '0, 0, "R4 data ws0");
      run_access(1, 1'b1, 14'h3001, 24'h123456, 2, "R4 prog ws2");
      run_access(0, 1'b0, 14'h0777, '0, 5, "R4 boot ws5");
      cfg_write(3, 1);
      run_access(2, 1'b1, 14'h0100, 24'hABCDEF, 0, "R4 space3 ignored data");
      run_access(0, 1'b0, 14'h0101, '0, 5, "R4 space3 ignored boot");
   endtask

   task automatic test_mid_write();
      int n = 0;
      @(negedge clk);
      set_req(0, 1'b1, 1'b0, 14'h0055, '0);
      @(negedge clk);
      n = 1;
      cfg_we = 1; cfg_space = 2'd0; cfg_ws = 3'd1;
      @(negedge clk);
      cfg_we = 0;
      n = 2;
      while (!boot_rdy && n < 40) begin
         @(negedge clk);
         n++;
      end
      set_req(0, 1'b0, 1'b0, '0, '0);
      chk(n == 6, "R4 running access keeps count", n, 6);
      run_access(0, 1'b0, 14'h0056, '0, 1, "R4 new count after write");
   endtask

   task automatic test_arb(input int hi, input int lo, input string tag);
      int n = 0;
      @(negedge clk);
      set_req(hi, 1'b1, 1'b0, 14'h0011, '0);
      set_req(lo, 1'b1, 1'b0, 14'h0022, '0);
      @(negedge clk);
      chk(sel_low(hi) && !sel_low(lo), {tag, " R6 winner strobes first"},
          sel_low(lo), 0);
      while (!rdy_of(hi) && n < 40) begin
         chk(!rdy_of(lo), {tag, " R7 loser ready low"}, rdy_of(lo), 0);
         @(negedge clk);
         n++;
      end
      set_req(hi, 1'b0, 1'b0, '0, '0);
      n = 0;
      while (!sel_low(lo) && n < 10) begin
         @(negedge clk);
         n++;
      end
      chk(n == 2, {tag, " R6 loser starts two cycles after winner ready"}, n, 2);
      n = 0;
      while (!rdy_of(lo) && n < 40) begin
         @(negedge clk);
         n++;
      end
      set_req(lo, 1'b0, 1'b0, '0, '0);
      @(negedge clk);
   endtask

   task automatic test_grant(input logic run_mode, input string tag);
      int n = 0;
      int bad = 0;
      grant_run_mode = run_mode;
      cfg_write(2, 4);
      @(negedge clk);
      set_req(2, 1'b1, 1'b1, 14'h0333, 24'h0F0F0F);
      @(negedge clk);
      @(negedge clk);
      ext_busreq_n = 0;
      while (!data_rdy && n < 40) begin
         @(negedge clk);
         n++;
         if (!ext_busgnt_n) bad++;
      end
      chk(bad == 0, {tag, " R8 grant held off during access"}, bad, 0);
      set_req(2, 1'b0, 1'b0, '0, '0);
      set_req(1, 1'b1, 1'b0, 14'h0444, '0);
      @(negedge clk);
      chk(ext_busgnt_n && !sel_low(1), {tag, " R8 idle cycle before grant"},
          ext_busgnt_n, 1);
      @(negedge clk);
      chk(!ext_busgnt_n, {tag, " R8 grant after access"}, ext_busgnt_n, 0);
      bad = 0;
      for (int k = 0; k < 3; k++) begin
         if (ext_drive_oe || ext_dout_oe || !ext_boot_sel_n || !ext_prog_sel_n ||
             !ext_data_sel_n || prog_rdy) bad++;
         if (core_halt != !run_mode) bad++;
         @(negedge clk);
      end
      chk(bad == 0, {tag, " R8 R10 bus floated and halt per mode"}, bad, 0);
      ext_busreq_n = 1;
      @(negedge clk);
      chk(ext_busgnt_n && !core_halt, {tag, " R9 grant dropped"}, ext_busgnt_n, 1);
      @(negedge clk);
      chk(sel_low(1) && ext_addr == 14'h0444, {tag, " R9 waiting access resumes"},
          sel_low(1), 1);
      n = 0;
      while (!prog_rdy && n < 40) begin
         @(negedge clk);
         n++;
      end
      set_req(1, 1'b0, 1'b0, '0, '0);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      test_reset();
      test_defaults();
      test_cfg();
      test_mid_write();
      test_arb(2, 1, "data>prog");
      test_arb(1, 0, "prog>boot");
      test_grant(1'b0, "halt mode");
      test_grant(1'b1, "run mode");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule